// File: doc/BRIEF.md
# Maskable Vectored Interrupt Controller

This block sits between three external interrupt request pins and a small 8-bit CPU core. It holds one global enable flag, which separate enable and disable commands set and clear. It also holds three maskable vectored lines. Each line has its own mask bit and its own pending state.

Lines 0 and 1 are level sensitive, and line 2 is captured on a rising edge. When interrupts are enabled and an unmasked line is pending, the block asserts `intr`. It also drives the restart address of the winning line on `vector`. The core accepts an interrupt by pulsing `inta`. Acceptance clears the global enable, and an accepted line 2 also loses its captured edge.

Software changes the masks through a mask-write port. It reads the whole control state back through a status byte that is always driven.

Top module: `vint_ctrl`

## Requirements
- R1: After reset the global enable is 0, all three masks are 1 (masked), all pending bits are 0 and `intr` is 0, so `status` reads 8'h07.
- R2: A cycle with `ei_cmd`=1 sets the global enable and a cycle with `di_cmd`=1 clears it, effective from the next clock edge. When both are 1 in the same cycle, the disable wins.
- R3: A cycle with `mask_wr`=1 and `mask_wdata[3]`=1 loads `mask_wdata[2:0]` into the masks of lines 2..0, where 1 means masked. With `mask_wdata[3]`=0 the masks keep their values.
- R4: The status byte is laid out as follows: bits [2:0] hold the masks of lines 2..0, bit [3] holds the global enable, bits [6:4] hold the pending bits of lines 2..0, and bit [7] is 0.
- R5: The pending bits of lines 0 and 1 follow the level of `irq_pin[0]` and `irq_pin[1]`, one clock later.
- R6: A rising edge on `irq_pin[2]` sets the line 2 pending bit one clock later. The bit stays set after the pin falls, and it stays set while the line is masked. It clears only on acceptance of line 2, or on a mask write with `mask_wdata[4]`=1. A new edge in the same cycle as a clear wins over the clear.
- R7: `intr` is 1 exactly when the global enable is 1 and at least one pending line is unmasked.
- R8: When several unmasked lines are pending, the highest-numbered line wins. `vector` is 8'h2C, 8'h34 or 8'h3C for line 0, 1 or 2 respectively.
- R9: `inta`=1 while `intr`=1 is an acceptance. It clears the global enable at the next edge. If line 2 was the winner, it also clears the line 2 pending bit. The pending bits of lines 0 and 1 are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ei_cmd | input | 1 | Enable command (one-cycle pulse) |
| di_cmd | input | 1 | Disable command (one-cycle pulse) |
| irq_pin | input | 3 | Request pins; bit 2 is edge captured, bits 1:0 are level sensitive |
| mask_wr | input | 1 | Mask-write strobe |
| mask_wdata | input | 8 | Mask-write data: [2:0] masks, [3] mask load enable, [4] clear line 2 pending |
| inta | input | 1 | Interrupt acknowledge from the core |
| intr | output | 1 | Interrupt request to the core |
| vector | output | 8 | Restart address of the winning line |
| status | output | 8 | Read-back byte: masks, global enable, pending bits |

## Verification
The hardest state to reach from the ports is a captured line 2 edge sitting next to level requests under an arbitrary mask and enable combination. The capture only exists after a pulse on the pin, and the pin has already returned low by the time the state is observed.

The stimulus therefore uses a three-cycle recipe for each combination. First, a mask write loads the masks and clears the old capture, while the level pins and the enable are set. Next, line 2 is pulsed. Finally, the pin is dropped before sampling. All 128 combinations of enable, masks, levels and capture are swept this way.

Acceptance is then exercised separately on line 2 and on line 1, to show that only the edge-captured line is cleared.

// File: rtl/vint_pkg.sv
package vint_pkg;
    localparam int unsigned NLINES  = 3;
    localparam int unsigned IDX_W   = $clog2(NLINES);
    localparam int unsigned NLEVEL  = NLINES - 1;
    localparam int unsigned EDGE_ID = NLINES - 1;

    // bit positions inside the mask-write byte
    localparam int unsigned WB_LOAD = 3;
    localparam int unsigned WB_CLR2 = 4;

    typedef struct packed {
        logic              ie;
        logic [NLINES-1:0] mask;
    } ctl_t;

    typedef struct packed {
        logic prev;
        logic pend;
    } edge_t;
endpackage

// File: rtl/vint_edge_latch.sv
module vint_edge_latch
    import vint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic clr,
    output logic pend
);
    edge_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = pin;
        if (clr) begin
            st_d.pend = 1'b0;
        end
        if (pin && !st_q.prev) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;
endmodule

// File: rtl/vint_level_sample.sv
module vint_level_sample #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin,
    output logic [WIDTH-1:0] lvl
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic bit_d, bit_q;

        always_comb begin
            bit_d = pin[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else begin
                bit_q <= bit_d;
            end
        end

        assign lvl[g] = bit_q;
    end
endmodule

// File: rtl/vint_prio.sv
module vint_prio #(
    parameter int unsigned N = 3,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        // ascending scan: the last hit, i.e. the highest index, is kept
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vint_ctrl.sv
module vint_ctrl
    import vint_pkg::*;
#(
    parameter logic [7:0]  VEC_BASE = 8'h2C,
    parameter int unsigned VEC_STEP = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ei_cmd,
    input  logic       di_cmd,
    input  logic [2:0] irq_pin,
    input  logic       mask_wr,
    input  logic [7:0] mask_wdata,
    input  logic       inta,
    output logic       intr,
    output logic [7:0] vector,
    output logic [7:0] status
);
    localparam logic [7:0] STEP8 = 8'(VEC_STEP);

    ctl_t              ctl_d, ctl_q;
    logic [NLEVEL-1:0] lvl;
    logic              pend_edge;
    logic [NLINES-1:0] pend;
    logic [NLINES-1:0] live;
    logic              any_live;
    logic [IDX_W-1:0]  win;
    logic              accept;
    logic              clr_edge;

    vint_level_sample #(.WIDTH(NLEVEL)) u_lvl (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (irq_pin[NLEVEL-1:0]),
        .lvl   (lvl)
    );

    vint_edge_latch u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (irq_pin[EDGE_ID]),
        .clr   (clr_edge),
        .pend  (pend_edge)
    );

    assign pend = {pend_edge, lvl};
    assign live = pend & ~ctl_q.mask;

    vint_prio #(.N(NLINES)) u_prio (
        .req (live),
        .any (any_live),
        .idx (win)
    );

    assign intr     = ctl_q.ie && any_live;
    assign accept   = inta && intr;
    assign clr_edge = (mask_wr && mask_wdata[WB_CLR2]) ||
                      (accept && (win == IDX_W'(EDGE_ID)));

    always_comb begin
        ctl_d = ctl_q;
        if (ei_cmd) begin
            ctl_d.ie = 1'b1;
        end
        if (di_cmd || accept) begin
            ctl_d.ie = 1'b0;
        end
        if (mask_wr && mask_wdata[WB_LOAD]) begin
            ctl_d.mask = mask_wdata[NLINES-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.ie   <= 1'b0;
            ctl_q.mask <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign vector = VEC_BASE + (8'(win) * STEP8);
    assign status = {1'b0, pend, ctl_q.ie, ctl_q.mask};
endmodule

// File: rtl/vint_ctrl_chk.sv
module vint_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ei_cmd,
    input logic       di_cmd,
    input logic [2:0] irq_pin,
    input logic       mask_wr,
    input logic [7:0] mask_wdata,
    input logic       inta,
    input logic       intr,
    input logic [7:0] vector,
    input logic [7:0] status
);
    // R7
    intr_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intr |-> status[3]);

    // R9
    accept_drops_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && intr && !ei_cmd) |=> !status[3]);

    // R2
    disable_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        di_cmd |=> !status[3]);

    // R3
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && mask_wdata[3]) |=> (status[2:0] == $past(mask_wdata[2:0])));

    // R3
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mask_wr && mask_wdata[3]) |=> $stable(status[2:0]));

    // R5
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status[5:4] == $past(irq_pin[1:0])));

    // R6
    edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pin[2] && !$past(irq_pin[2])) |=> status[6]);

    // R8
    top_line_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (intr && status[6] && !status[2]) |-> (vector == 8'h3C));

    // R4
    spare_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status[7]);
endmodule

bind vint_ctrl vint_ctrl_chk u_chk (.*);

// File: tb/vint_ctrl_bench.sv
`timescale 1ns/1ps
module vint_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ei_cmd = 1'b0;
    logic       di_cmd = 1'b0;
    logic [2:0] irq_pin = 3'b000;
    logic       mask_wr = 1'b0;
    logic [7:0] mask_wdata = 8'h00;
    logic       inta = 1'b0;
    logic       intr;
    logic [7:0] vector;
    logic [7:0] status;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vint_ctrl u_vint_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ei_cmd     (ei_cmd),
        .di_cmd     (di_cmd),
        .irq_pin    (irq_pin),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .inta       (inta),
        .intr       (intr),
        .vector     (vector),
        .status     (status)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        ei_cmd = 0; di_cmd = 0; mask_wr = 0; mask_wdata = 0; inta = 0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 status", status, 8'h07);
        check("R1 intr", intr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 status after release", status, 8'h07);

        // R4 R5 R6 R7 R8: sweep enable, masks, levels and the line 2 capture
        for (int ie = 0; ie < 2; ie++) begin
            for (int m = 0; m < 8; m++) begin
                for (int lv = 0; lv < 4; lv++) begin
                    for (int p2 = 0; p2 < 2; p2++) begin
                        logic [2:0] live;
                        int         hi;
                        mask_wr = 1; mask_wdata = {3'b000, 1'b1, 1'b1, 3'(m)};
                        irq_pin = {1'b0, 2'(lv)};
                        ei_cmd = (ie == 1); di_cmd = (ie == 0);
                        @(negedge clk);
                        idle();
                        irq_pin[2] = 1'(p2);
                        @(negedge clk);
                        irq_pin[2] = 1'b0;
                        @(negedge clk);
                        live = {1'(p2), 2'(lv)} & ~3'(m);
                        hi = live[2] ? 2 : (live[1] ? 1 : 0);
                        check("R4 R5 R6 status", status,
                              {1'b0, 1'(p2), 2'(lv), 1'(ie), 3'(m)});
                        check("R7 intr", intr, (ie == 1) && (live != 0));
                        if (intr) check("R8 vector", vector, 8'h2C + 8 * hi);
                    end
                end
            end
        end

        // R3: write without load bit keeps masks
        idle(); irq_pin = 3'b000;
        mask_wr = 1; mask_wdata = 8'h08;
        @(negedge clk);
        mask_wr = 1; mask_wdata = 8'h07;
        @(negedge clk);
        idle();
        check("R3 masks kept", status[2:0], 3'b000);

        // R2: simultaneous enable and disable, then each alone
        ei_cmd = 1; di_cmd = 1;
        @(negedge clk);
        idle();
        check("R2 disable wins", status[3], 0);
        ei_cmd = 1;
        @(negedge clk);
        idle();
        check("R2 enable", status[3], 1);
        di_cmd = 1;
        @(negedge clk);
        idle();
        check("R2 disable", status[3], 0);

        // R9: accept line 2, then line 1
        ei_cmd = 1; irq_pin = 3'b111;
        @(negedge clk);
        idle(); irq_pin = 3'b011;
        @(negedge clk);
        check("R9 setup intr", intr, 1);
        check("R8 line 2 vector", vector, 8'h3C);
        inta = 1;
        @(negedge clk);
        idle();
        check("R9 enable cleared", status[3], 0);
        check("R9 line 2 pending cleared", status[6:4], 3'b011);
        check("R9 intr low", intr, 0);
        ei_cmd = 1;
        @(negedge clk);
        idle();
        check("R8 line 1 vector", vector, 8'h34);
        inta = 1;
        @(negedge clk);
        idle();
        check("R9 level pendings kept", status[6:3], 4'b0110);

        // R6: masked capture stays visible, clear bit removes it
        irq_pin = 3'b000;
        mask_wr = 1; mask_wdata = 8'h0F; ei_cmd = 1;
        @(negedge clk);
        idle(); irq_pin[2] = 1;
        @(negedge clk);
        irq_pin[2] = 0;
        @(negedge clk);
        check("R6 masked capture", status, 8'h4F);
        check("R7 masked no intr", intr, 0);
        mask_wr = 1; mask_wdata = 8'h10;
        @(negedge clk);
        idle();
        check("R6 cleared by write", status, 8'h0F);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule